// File: doc/BRIEF.md
# Region-of-Interest Sampling Readout Controller

This block is the digital control for a circular array of sampling cells. While idle it sweeps a write pointer around the ring, one cell per clock and wrapping back to cell 0. A trigger starts a programmable delay countdown, and the pointer keeps moving during the countdown. When the count runs out, the pointer halts and the cell where it stopped is latched.

After the stop, the block walks a short window of cells. The window begins at the stop cell and wraps around the ring if needed. It runs at a slower pace than sampling: one cell every `RD_DIV` clocks. For each cell it emits the cell index with a valid strobe, and it flags the final cell. When the window is finished, sampling resumes from the stopped position. A busy output covers the whole span from trigger to last cell, and triggers that arrive in that span are dropped.

The control has three states:
- `ST_SAMPLE`: free-running pointer.
- `ST_DELAY`: countdown, pointer still moving.
- `ST_READ`: pointer frozen, window walked.

The transitions are:
- ARM: `ST_SAMPLE`→`ST_DELAY` on a trigger.
- HALT: `ST_DELAY`→`ST_READ` when the countdown is zero.
- DONE: `ST_READ`→`ST_SAMPLE` on the last cell.

Top module: `roi_readout_ctrl`

## Requirements
- R1: While in `ST_SAMPLE` the write pointer advances by one cell per clock and goes from CELLS-1 to 0; after reset it is 0, with busy and valid low.
- R2: When the trigger is sampled at a clock edge with pointer value P and delay D, the pointer keeps advancing for D further edges and then freezes at (P+1+D) mod CELLS. With D=0 the stop falls on the cycle after the trigger.
- R3: The stop cell output holds (P+1+D) mod CELLS from the stop until the next stop.
- R4: The first readout strobe appears in the cycle right after the stop, with address equal to the stop cell. Strobe k carries address (stop+k) mod CELLS, and consecutive strobes are exactly RD_DIV cycles apart.
- R5: The last flag is high only on strobe N-1, where N is the length value captured at the trigger. A length value of 0 means N=CELLS, which is the whole ring.
- R6: Busy is high from the cycle after the trigger through the cycle of the last strobe, and low in the cycle after that. Busy is high whenever a strobe is high.
- R7: A trigger, a delay change or a length change while busy has no effect on the current window, and no event follows from it.
- R8: In the first cycle after busy falls the pointer still shows the stop cell, and one cycle later it shows stop+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger, sampled each rising edge |
| delay_i | input | DLY_W | Extra stop delay in cycles, captured at trigger |
| roi_len_i | input | ADDR_W | Window length in cells, 0 = whole ring, captured at trigger |
| wr_ptr_o | output | ADDR_W | Current write cell |
| busy_o | output | 1 | Delay or readout in progress |
| stop_cell_o | output | ADDR_W | Latched stop cell |
| rd_valid_o | output | 1 | Readout strobe |
| rd_addr_o | output | ADDR_W | Cell index being read |
| rd_last_o | output | 1 | Final cell of the window |

## Verification
The bench builds the block with a 64-cell ring and a readout pace of one cell per 3 clocks. The small ring puts pointer wrap-around within reach several times, including during long delays (300 and 1000 cycles), and it lets a whole-ring window (length code 0) finish in about 190 cycles. The pace of 3 makes the strobe spacing and the single-cycle strobes observable. Windows are placed so that they straddle the CELLS-1 to 0 boundary, and extra triggers are fired into the middle of a busy span to show that they are dropped.

// File: rtl/roi_pkg.sv
package roi_pkg;
    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_DELAY  = 2'd1,
        ST_READ   = 2'd2
    } roi_state_e;
endpackage

// File: rtl/roi_ring_ptr.sv
module roi_ring_ptr #(
    parameter int CELLS = 1024,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(CELLS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (adv_i) begin
            ptr_o <= (ptr_o == LAST_CELL) ? '0 : ptr_o + 1'b1;
        end
    end

    // R1: the pointer wraps from the last cell to 0
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && ptr_o == LAST_CELL) |=> (ptr_o == '0));
endmodule

// File: rtl/roi_delay_cnt.sv
module roi_delay_cnt #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] value_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R2: a loaded value counts down by one on each decrement
    assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && dec_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/roi_read_seq.sv
module roi_read_seq #(
    parameter int CELLS  = 1024,
    parameter int RD_DIV = 8,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_m1_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] k_q;
    logic [ADDR_W:0]   sum;
    logic              tick;

    generate
        if (RD_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(RD_DIV);
            localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(RD_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (start_i) begin
                    div_q <= '0;
                end else if (run_i) begin
                    div_q <= (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
                end
            end

            assign tick = run_i && (div_q == '0);

            // R4: strobes are single-cycle when the pace is slower than one per clock
            assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |=> !valid_o);
        end else begin : g_nodiv
            assign tick = run_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= '0;
        end else if (start_i) begin
            k_q <= '0;
        end else if (tick) begin
            k_q <= k_q + 1'b1;
        end
    end

    assign sum     = {1'b0, base_i} + {1'b0, k_q};
    assign addr_o  = (sum >= (ADDR_W+1)'(CELLS)) ? ADDR_W'(sum - (ADDR_W+1)'(CELLS))
                                                 : sum[ADDR_W-1:0];
    assign valid_o = tick;
    assign last_o  = tick && (k_q == len_m1_i);
endmodule

// File: rtl/roi_readout_ctrl.sv
module roi_readout_ctrl
    import roi_pkg::*;
#(
    parameter int CELLS  = 1024,
    parameter int DLY_W  = 16,
    parameter int RD_DIV = 8,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [ADDR_W-1:0] roi_len_i,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] stop_cell_o,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_last_o
);
    roi_state_e        state_q, state_d;
    logic              adv, load, start, dly_zero;
    logic [ADDR_W-1:0] len_m1_q, stop_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        load    = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            ST_SAMPLE: begin
                adv = 1'b1;
                if (trig_i) begin
                    load    = 1'b1;
                    state_d = ST_DELAY;      // ARM
                end
            end
            ST_DELAY: begin
                if (dly_zero) begin
                    start   = 1'b1;
                    state_d = ST_READ;       // HALT
                end else begin
                    adv = 1'b1;
                end
            end
            ST_READ: begin
                if (rd_last_o) begin
                    state_d = ST_SAMPLE;     // DONE
                end
            end
            default: state_d = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_m1_q <= '0;
            stop_q   <= '0;
        end else begin
            if (load)  len_m1_q <= roi_len_i - 1'b1;
            if (start) stop_q   <= wr_ptr_o;
        end
    end

    roi_ring_ptr #(.CELLS(CELLS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .ptr_o(wr_ptr_o)
    );

    roi_delay_cnt #(.DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load_i(load), .value_i(delay_i),
        .dec_i(state_q == ST_DELAY), .zero_o(dly_zero)
    );

    roi_read_seq #(.CELLS(CELLS), .RD_DIV(RD_DIV)) u_rd (
        .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(state_q == ST_READ),
        .base_i(stop_q), .len_m1_i(len_m1_q),
        .valid_o(rd_valid_o), .addr_o(rd_addr_o), .last_o(rd_last_o)
    );

    assign busy_o      = (state_q != ST_SAMPLE);
    assign stop_cell_o = stop_q;

    // R1: one cell per clock while sampling
    assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |=> (wr_ptr_o == ADDR_W'((32'($past(wr_ptr_o)) + 1) % CELLS)));
    // R2: pointer frozen during readout
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> $stable(wr_ptr_o));
    // R4: first strobe follows the stop and points at the stop cell
    assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rd_valid_o && rd_addr_o == wr_ptr_o));
    // R6: busy covers every strobe and drops after the last one
    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> busy_o);
    assert_last_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last_o |=> !busy_o);
    // R7: a trigger while busy leaves the captured length alone
    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i) |=> $stable(len_m1_q));
endmodule

// File: tb/roi_readout_ctrl_bench.sv
module roi_readout_ctrl_bench;
    localparam int CELLS  = 64;
    localparam int DLY_W  = 16;
    localparam int RD_DIV = 3;
    localparam int AW     = $clog2(CELLS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_i = 1'b0;
    logic [DLY_W-1:0] delay_i = '0;
    logic [AW-1:0] roi_len_i = '0;
    logic [AW-1:0] wr_ptr_o, stop_cell_o, rd_addr_o;
    logic          busy_o, rd_valid_o, rd_last_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct packed { logic [AW-1:0] addr; logic last; } item_t;
    item_t exp_q[$];

    roi_readout_ctrl #(.CELLS(CELLS), .DLY_W(DLY_W), .RD_DIV(RD_DIV)) u_roi_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .delay_i(delay_i),
        .roi_len_i(roi_len_i), .wr_ptr_o(wr_ptr_o), .busy_o(busy_o),
        .stop_cell_o(stop_cell_o), .rd_valid_o(rd_valid_o),
        .rd_addr_o(rd_addr_o), .rd_last_o(rd_last_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pop and compare every strobe, check spacing inside a window
    bit in_evt = 1'b0;
    int last_cyc = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected strobe", int'(rd_addr_o), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(rd_addr_o == e.addr, "R4 address", int'(rd_addr_o), int'(e.addr));
                chk(rd_last_o == e.last, "R5 last flag", int'(rd_last_o), int'(e.last));
                chk(busy_o, "R6 busy with strobe", int'(busy_o), 1);
            end
            if (in_evt) chk(cyc - last_cyc == RD_DIV, "R4 spacing", cyc - last_cyc, RD_DIV);
            last_cyc = cyc;
            in_evt = !rd_last_o;
        end
    end

    // Driver: one trigger, expected window pushed into the scoreboard
    task automatic run_event(input int d, input int len, input bit noise);
        int p, stop, n;
        @(negedge clk);
        chk(!busy_o, "R6 idle before trigger", int'(busy_o), 0);
        p = int'(wr_ptr_o);
        stop = (p + 1 + d) % CELLS;
        n = (len == 0) ? CELLS : len;
        for (int k = 0; k < n; k++) begin
            item_t e;
            e.addr = AW'((stop + k) % CELLS);
            e.last = (k == n - 1);
            exp_q.push_back(e);
        end
        trig_i = 1'b1; delay_i = DLY_W'(d); roi_len_i = AW'(len);
        for (int i = 1; i <= d + 1; i++) begin
            @(negedge clk);
            if (i == 1) begin
                trig_i = 1'b0;
                chk(busy_o, "R6 busy after trigger", int'(busy_o), 1);
                if (noise) begin delay_i = 16'd7; roi_len_i = AW'(2); end
            end
            if (noise && i == 2) trig_i = 1'b1;   // R7 trigger during countdown
            if (noise && i == 3) trig_i = 1'b0;
        end
        chk(wr_ptr_o == AW'(stop), "R2 stop position", int'(wr_ptr_o), stop);
        @(negedge clk);
        chk(rd_valid_o, "R4 first strobe timing", int'(rd_valid_o), 1);
        chk(wr_ptr_o == AW'(stop), "R2 pointer frozen", int'(wr_ptr_o), stop);
        chk(stop_cell_o == AW'(stop), "R3 stop cell", int'(stop_cell_o), stop);
        if (noise) begin
            trig_i = 1'b1; delay_i = '0; roi_len_i = AW'(1);   // R7 trigger during readout
            @(negedge clk);
            trig_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        chk(exp_q.size() == 0, "R5 window complete", exp_q.size(), 0);
        chk(stop_cell_o == AW'(stop), "R3 stop cell held", int'(stop_cell_o), stop);
        chk(wr_ptr_o == AW'(stop), "R8 resume point", int'(wr_ptr_o), stop);
        @(negedge clk);
        chk(wr_ptr_o == AW'((stop + 1) % CELLS), "R8 resume step", int'(wr_ptr_o), (stop + 1) % CELLS);
        chk(!busy_o, "R7 no follow-on event", int'(busy_o), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ptr_o == AW'(1), "R1 reset pointer", int'(wr_ptr_o), 1);
        chk(!busy_o && !rd_valid_o, "R1 reset idle", int'(busy_o || rd_valid_o), 0);
        // R1 stepping and wrap
        for (int i = 0; i < 3; i++) begin
            int prev;
            prev = int'(wr_ptr_o);
            @(negedge clk);
            chk(int'(wr_ptr_o) == (prev + 1) % CELLS, "R1 step", int'(wr_ptr_o), (prev + 1) % CELLS);
        end
        while (wr_ptr_o != AW'(CELLS - 1)) @(negedge clk);
        @(negedge clk);
        chk(wr_ptr_o == '0, "R1 wrap", int'(wr_ptr_o), 0);

        run_event(0, 4, 1'b0);          // R2 zero delay
        run_event(5, 7, 1'b1);          // R7 triggers and input changes while busy
        while (wr_ptr_o != AW'(CELLS - 5)) @(posedge clk);
        run_event(1, 5, 1'b0);          // R4 window across the wrap
        run_event(300, 0, 1'b0);        // R5 whole ring, long delay
        run_event(1000, 1, 1'b1);       // R5 single cell
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0 && !rd_valid_o, "R7 quiet at end", exp_q.size(), 0);
        finish_run();
    end
endmodule